// File: doc/BRIEF.md
# Floppy Controller Soft-Switch Front End

This block sits between a host bus and a floppy disk controller's serial data path. The host has no register index to write. Every access to one of sixteen addresses has a side effect: it sets or clears one of eight one-bit switches. Four of these switches drive general phase/control lines toward the drive. One switch turns the drive on, one picks which of two drives receives the enable, and two (called Q6 and Q7 here) steer host reads and writes to internal registers.

The block holds a write-only mode register, builds a status byte and a handshake byte, and returns the selected byte one cycle after a read access. It forwards data-register writes to the serial path as a one-cycle strobe. It also runs the motor-off delay: when the enable switch is cleared, the drive normally stays active for `OFF_CYCLES` core clocks. A mode bit turns this delay off. While the drive is active, including during that delay, the mode register cannot be written.

Top module: `diskSwitchIf`

## Requirements
- R1: An access (read or write) with `busSel` high at address A writes bit A[0] into switch number A[3:1], taking effect at that clock edge. Switch numbering: 0..3 are the control lines `ctlLines[0..3]`, 4 is drive enable, 5 is drive select, 6 is Q6, 7 is Q7.
- R2: A read access loads `busRdata` at its clock edge, and the value is held until the next read. The source is chosen from the Q6/Q7 values that include the update made by this same access: Q6=0,Q7=0 returns `rdData`; Q6=0,Q7=1 returns the handshake byte; Q6=1,Q7=0 returns the status byte.
- R3: The status byte has `senseIn` in bit 7, 0 in bit 6, the drive-active flag (as it stood before the access) in bit 5, and mode bits 4:0 in bits 4:0.
- R4: The handshake byte has `hsReady` in bit 7, `hsNoUnderrun` in bit 6, and zeros in bits 5:0.
- R5: A read with Q6=1 and Q7=1 returns 0x00. A write to an even address changes only the addressed switch: it writes neither the mode register nor the data register.
- R6: A write to an odd address with Q6=1 and Q7=1, while the drive is inactive, stores `busWdata[4:0]` into the mode register. Bits 7:5 are dropped.
- R7: The same write while the drive is active pulses `dataWrStb` for the one cycle after the edge, with `dataWrByte` equal to the written byte. The mode register is left unchanged.
- R8: With mode bit 2 = 0, clearing the enable switch keeps the drive active for exactly `OFF_CYCLES` further cycles. Mode writes are refused during that window.
- R9: With mode bit 2 = 1, clearing the enable switch makes the drive inactive at that same edge.
- R10: Setting the enable switch during the delay cancels the countdown. A later clear starts a full delay again.
- R11: While active, the drive enable reaches `drive1En` when the select switch is 0 and `drive2En` when it is 1. The two outputs are never high together.
- R12: Reset clears all eight switches, the mode register, the countdown, `busRdata` and `dataWrStb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one per clock |
| busWr | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | 4 | Access address |
| busWdata | input | 8 | Host write byte |
| busRdata | output | 8 | Byte returned by the last read |
| senseIn | input | 1 | Drive sense line |
| rdData | input | 8 | Read byte from the serial path |
| hsReady | input | 1 | Serial path ready for the next write byte |
| hsNoUnderrun | input | 1 | 1 = no write underrun has occurred |
| dataWrStb | output | 1 | One-cycle data-register write strobe |
| dataWrByte | output | 8 | Byte that goes with `dataWrStb` |
| ctlLines | output | 4 | Phase/control lines to the drive |
| drive1En | output | 1 | Enable for drive 1 |
| drive2En | output | 1 | Enable for drive 2 |
| modeOut | output | 5 | Current mode register |

## Verification
Results fall due as follows:
- Switch outputs, the mode register and the drive enables change at the edge that samples the access, so they are due one cycle after it.
- The read byte and the data strobe are registered at that same edge, so they are also visible in the half-cycle that follows.
- A motor-off delay counts `OFF_CYCLES` further edges after the clearing edge.

The bench drives inputs on falling edges and advances a behavioural model on each rising edge. It compares every output with the model on the next falling edge. Directed checks count the active cycles of the delay one falling edge at a time, so an off-by-one in the countdown is caught.

// File: rtl/diskSwPkg.sv
package diskSwPkg;
  localparam int SW_N    = 8;
  localparam int SW_EN   = 4;
  localparam int SW_SEL  = 5;
  localparam int SW_Q6   = 6;
  localparam int SW_Q7   = 7;
  localparam int MODE_W  = 5;
  localparam int NODLY_B = 2;

  // order matches {q6,q7}
  typedef enum logic [1:0] {RD_DATA, RD_HSHK, RD_STAT, RD_NONE} rdSrcE;

  typedef struct packed {
    logic       swWe;
    logic [2:0] swIdx;
    logic       swVal;
    logic       rdWe;
    rdSrcE      rdSrc;
    logic       modeWe;
    logic       dataWe;
  } ctlStbT;
endpackage

// File: rtl/diskSwCtrl.sv
module diskSwCtrl
  import diskSwPkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [3:0] busAddr,
  input  logic       q6Now,
  input  logic       q7Now,
  input  logic       driveActive,
  output ctlStbT     stb
);
  logic q6Nx, q7Nx, wrOdd;

  always_comb begin
    q6Nx = (busSel && busAddr[3:1] == 3'(SW_Q6)) ? busAddr[0] : q6Now;
    q7Nx = (busSel && busAddr[3:1] == 3'(SW_Q7)) ? busAddr[0] : q7Now;
    wrOdd = busSel && busWr && busAddr[0] && q6Nx && q7Nx;
    stb.swWe   = busSel;
    stb.swIdx  = busAddr[3:1];
    stb.swVal  = busAddr[0];
    stb.rdWe   = busSel && !busWr;
    stb.rdSrc  = rdSrcE'({q6Nx, q7Nx});
    stb.modeWe = wrOdd && !driveActive;
    stb.dataWe = wrOdd && driveActive;
  end
endmodule

// File: rtl/diskSwOffTimer.sv
module diskSwOffTimer #(
  parameter int OFF_CYCLES = 7000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enNow,
  input  logic enNext,
  input  logic noDelay,
  output logic busy
);
  localparam int CW = $clog2(OFF_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                 cnt <= '0;
    else if (enNext)           cnt <= '0;
    else if (enNow)            cnt <= noDelay ? '0 : CW'(OFF_CYCLES);
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/diskSwDatapath.sv
module diskSwDatapath
  import diskSwPkg::*;
#(
  parameter int OFF_CYCLES = 7000000,
  parameter int DW         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStbT            stb,
  input  logic [DW-1:0]     wdata,
  input  logic              senseIn,
  input  logic [DW-1:0]     rdData,
  input  logic              hsReady,
  input  logic              hsNoUnderrun,
  output logic [SW_N-1:0]   swState,
  output logic [MODE_W-1:0] modeReg,
  output logic              driveActive,
  output logic [DW-1:0]     rdByte,
  output logic              wrStb,
  output logic [DW-1:0]     wrByte
);
  logic enNext, timerBusy;
  logic [DW-1:0] statByte, hshkByte, rdMux;

  for (genvar i = 0; i < SW_N; i++) begin : gSw
    always_ff @(posedge clk) begin
      if (!rstN) swState[i] <= 1'b0;
      else if (stb.swWe && stb.swIdx == 3'(i)) swState[i] <= stb.swVal;
    end
  end

  assign enNext = (stb.swWe && stb.swIdx == 3'(SW_EN)) ? stb.swVal : swState[SW_EN];

  diskSwOffTimer #(.OFF_CYCLES(OFF_CYCLES)) uTimer (
    .clk     (clk),
    .rstN    (rstN),
    .enNow   (swState[SW_EN]),
    .enNext  (enNext),
    .noDelay (modeReg[NODLY_B]),
    .busy    (timerBusy)
  );

  assign driveActive = swState[SW_EN] || timerBusy;

  always_comb begin
    statByte = '0;
    statByte[DW-1] = senseIn;
    statByte[DW-3] = driveActive;
    statByte[MODE_W-1:0] = modeReg;
    hshkByte = '0;
    hshkByte[DW-1] = hsReady;
    hshkByte[DW-2] = hsNoUnderrun;
    unique case (stb.rdSrc)
      RD_DATA: rdMux = rdData;
      RD_HSHK: rdMux = hshkByte;
      RD_STAT: rdMux = statByte;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      rdByte  <= '0;
      wrStb   <= 1'b0;
      wrByte  <= '0;
    end else begin
      wrStb <= stb.dataWe;
      if (stb.dataWe) wrByte  <= wdata;
      if (stb.modeWe) modeReg <= wdata[MODE_W-1:0];
      if (stb.rdWe)   rdByte  <= rdMux;
    end
  end
endmodule

// File: rtl/diskSwitchIf.sv
module diskSwitchIf
  import diskSwPkg::*;
#(
  parameter int OFF_CYCLES = 7000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [3:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       senseIn,
  input  logic [7:0] rdData,
  input  logic       hsReady,
  input  logic       hsNoUnderrun,
  output logic       dataWrStb,
  output logic [7:0] dataWrByte,
  output logic [3:0] ctlLines,
  output logic       drive1En,
  output logic       drive2En,
  output logic [4:0] modeOut
);
  ctlStbT stb;
  logic [SW_N-1:0] swState;
  logic driveActive;

  diskSwCtrl uCtrl (
    .busSel      (busSel),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .q6Now       (swState[SW_Q6]),
    .q7Now       (swState[SW_Q7]),
    .driveActive (driveActive),
    .stb         (stb)
  );

  diskSwDatapath #(.OFF_CYCLES(OFF_CYCLES), .DW(8)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wdata        (busWdata),
    .senseIn      (senseIn),
    .rdData       (rdData),
    .hsReady      (hsReady),
    .hsNoUnderrun (hsNoUnderrun),
    .swState      (swState),
    .modeReg      (modeOut),
    .driveActive  (driveActive),
    .rdByte       (busRdata),
    .wrStb        (dataWrStb),
    .wrByte       (dataWrByte)
  );

  assign ctlLines = swState[3:0];
  assign drive1En = driveActive && !swState[SW_SEL];
  assign drive2En = driveActive &&  swState[SW_SEL];
endmodule

// File: rtl/diskSwitchIfChk.sv
module diskSwitchIfChk (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic [3:0] busAddr,
  input logic       dataWrStb,
  input logic       drive1En,
  input logic       drive2En,
  input logic [4:0] modeOut
);
  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(drive1En && drive2En)); // R11

  AST_MODE_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeOut) |-> $past(!drive1En && !drive2En)); // R6

  AST_STB_ODD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    dataWrStb |-> $past(busSel && busWr && busAddr[0])); // R7

  AST_IMMEDIATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeOut[2]) && $past(busSel && busAddr == 4'h8)) |-> !(drive1En || drive2En)); // R9
endmodule

bind diskSwitchIf diskSwitchIfChk uChk (.*);

// File: tb/tb_diskSwitchIf.sv
module tb_diskSwitchIf;
  localparam int CLK_PERIOD = 10;
  localparam int OFF = 20;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWr = 0;
  logic [3:0] busAddr = 0;
  logic [7:0] busWdata = 0, rdData = 0;
  logic senseIn = 0, hsReady = 0, hsNoUnderrun = 0;
  logic [7:0] busRdata, dataWrByte;
  logic dataWrStb, drive1En, drive2En;
  logic [3:0] ctlLines;
  logic [4:0] modeOut;

  int total = 0, bad = 0;

  diskSwitchIf #(.OFF_CYCLES(OFF)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] mSw, nSw, mRd, mByte;
  logic [4:0] mMode;
  logic mStb, preAct;
  int mCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      mSw = 0; mRd = 0; mByte = 0; mMode = 0; mStb = 0; mCnt = 0;
    end else begin
      preAct = mSw[4] || (mCnt != 0);
      nSw = mSw;
      mStb = 0;
      if (busSel) nSw[busAddr[3:1]] = busAddr[0];
      if (busSel && !busWr)
        case ({nSw[6], nSw[7]})
          2'b00: mRd = rdData;
          2'b01: mRd = {hsReady, hsNoUnderrun, 6'b0};
          2'b10: mRd = {senseIn, 1'b0, preAct, mMode};
          default: mRd = 8'h00;
        endcase
      if (busSel && busWr && busAddr[0] && nSw[6] && nSw[7]) begin
        if (preAct) begin mStb = 1; mByte = busWdata; end
        else mMode = busWdata[4:0];
      end
      if (nSw[4]) mCnt = 0;
      else if (mSw[4]) mCnt = mMode[2] ? 0 : OFF;
      else if (mCnt > 0) mCnt = mCnt - 1;
      mSw = nSw;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      automatic logic act = mSw[4] || (mCnt != 0);
      chk("R1 ctlLines", 32'(ctlLines), 32'(mSw[3:0]));
      chk("R11 drive1En", 32'(drive1En), 32'(act && !mSw[5]));
      chk("R11 drive2En", 32'(drive2En), 32'(act && mSw[5]));
      chk("R6 modeOut", 32'(modeOut), 32'(mMode));
      chk("R2 busRdata", 32'(busRdata), 32'(mRd));
      chk("R7 dataWrStb", 32'(dataWrStb), 32'(mStb));
      if (mStb) chk("R7 dataWrByte", 32'(dataWrByte), 32'(mByte));
    end
  end

  task automatic acc(input logic [3:0] a, input logic w = 0, input logic [7:0] d = 0);
    busSel = 1; busWr = w; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic countActive(output int n);
    n = 0;
    while (drive1En && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R12 reset drives", 32'({drive1En, drive2En, ctlLines}), 32'h0);
    chk("R12 reset mode", 32'(modeOut), 32'h0);
    rstN = 1;
    @(negedge clk);
    // mode write while idle, upper bits dropped
    acc(4'hD); acc(4'hF, 1, 8'hFB);
    chk("R6 mode store", 32'(modeOut), 32'h1B);
    senseIn = 1;
    acc(4'hE);
    chk("R3 status idle", 32'(busRdata), 32'h9B);
    acc(4'h9);
    acc(4'hE);
    chk("R3 status active", 32'(busRdata), 32'hBB);
    acc(4'hF, 1, 8'h55);
    chk("R7 strobe", 32'(dataWrStb), 32'h1);
    chk("R7 byte", 32'(dataWrByte), 32'h55);
    chk("R7 mode kept", 32'(modeOut), 32'h1B);
    acc(4'hB);
    chk("R11 drive2", 32'({drive1En, drive2En}), 32'h1);
    acc(4'hA);
    chk("R11 drive1", 32'({drive1En, drive2En}), 32'h2);
    acc(4'h1); acc(4'h3, 1, 8'h00); acc(4'h5);
    chk("R1 lines set", 32'(ctlLines), 32'h7);
    acc(4'h2);
    chk("R1 line clear", 32'(ctlLines), 32'h5);
    hsReady = 1; hsNoUnderrun = 0;
    acc(4'hC);
    chk("R4 handshake", 32'(busRdata), 32'h80);
    rdData = 8'hD5;
    acc(4'hE);
    chk("R2 data read", 32'(busRdata), 32'hD5);
    acc(4'hD); acc(4'hF);
    chk("R5 both-set read", 32'(busRdata), 32'h00);
    acc(4'h0, 1, 8'hAA);
    chk("R5 even write no strobe", 32'(dataWrStb), 32'h0);
    chk("R5 even write mode kept", 32'(modeOut), 32'h1B);
    // delayed off with refused mode write
    acc(4'h8);
    n = drive1En ? 1 : 0;
    acc(4'hF, 1, 8'h04);
    chk("R8 mode refused", 32'(modeOut), 32'h1B);
    chk("R8 write as data", 32'(dataWrStb), 32'h1);
    if (drive1En) begin
      int m;
      @(negedge clk);
      n++;
      countActive(m);
      n += m;
    end
    chk("R8 delay length", 32'(n), 32'(OFF));
    // re-enable cancels
    acc(4'h9); acc(4'h8);
    repeat (5) @(negedge clk);
    acc(4'h9);
    repeat (30) @(negedge clk);
    chk("R10 still on", 32'(drive1En), 32'h1);
    acc(4'h8);
    countActive(n);
    chk("R10 full restart", 32'(n), 32'(OFF));
    // no-delay mode
    acc(4'hF, 1, 8'h1F);
    chk("R9 mode set", 32'(modeOut), 32'h1F);
    acc(4'h9); acc(4'h8);
    chk("R9 immediate off", 32'({drive1En, drive2En}), 32'h0);
    // reset mid-run
    acc(4'h9); acc(4'h7);
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 reset drives", 32'({drive1En, drive2En, ctlLines}), 32'h0);
    chk("R12 reset regs", 32'({modeOut, busRdata, dataWrStb}), 32'h0);
    rstN = 1;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule